// File: doc/BRIEF.md
# Data-Side Address Router with Special-Function Window

This block sits between the operand-address logic of a small microcontroller core and its data-side memories. For each valid request it produces four things one clock later. The first is a 24-bit physical address. The second is the matching word address. The third is a one-hot target select that picks internal data RAM, on-chip special-function registers, the external special-function interface or external data memory. The fourth is a set of qualifier flags for bit access and alignment.

A request carries a 16-bit offset and four qualifiers. The qualifiers say whether the offset came from a direct operand field or an indirect pointer, whether the access is a byte or a word, whether it is a single-bit access, and whether it is a stack access. The request also supplies the data and extra segment bytes, and a select that picks one of them.

Direct operands reach an 11-bit space. Its lower half is data RAM and its upper half is the special-function window. The window ignores segments entirely. Indirect pointers can never reach the window: they always go to data memory, and internal RAM wins over external memory for the low offsets of a segment.

Top module: `dmem_addr_router`

## Requirements
- R1: A valid direct request whose low 11 offset bits (the effective direct address) are below 0x400 selects internal RAM (sel bit 0). Its physical address is {segment byte, 5'b0, direct address}, and offset bits 15..11 are ignored.
- R2: A valid direct request with direct address 0x400..0x5FF selects on-chip SFR (sel bit 1). A valid direct request with direct address 0x600..0x7FF selects external SFR (sel bit 2). In both cases the physical address is the direct address zero-extended to 24 bits, whatever the segment bytes hold.
- R3: The bitable output is 1 exactly when the selected target is an SFR and the direct address is 0x400..0x43F. The bit_err output is 1 exactly when req_bit is set, the target is an SFR, and bitable is 0.
- R4: A valid indirect request never selects either SFR target, even when its offset lies in 0x400..0x7FF. It goes to data memory with physical address {segment byte, offset}.
- R5: The segment byte is ds_i when req_stack is 1, whatever req_use_es holds. Otherwise it is es_i when req_use_es is 1 and ds_i when req_use_es is 0.
- R6: For a word request, bit 0 of the physical address is 0. word_addr always equals phys_addr bits 23..1, so the low byte of a word lies at the even address.
- R7: A valid indirect request whose aligned offset is below INT_RAM_BYTES (default 1024) selects internal RAM (sel bit 0). Otherwise it selects external memory (sel bit 3).
- R8: align_warn is 1 for exactly the one output cycle of a word request with an odd offset. That request is still routed with the aligned address.
- R9: Outputs appear one clock after the request. sel is one-hot when out_valid is 1. When the request was not valid, out_valid, sel, the flags and both addresses are all 0.
- R10: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_offset | input | 16 | Operand offset |
| req_direct | input | 1 | 1 = direct operand, 0 = indirect pointer |
| req_word | input | 1 | 1 = word access, 0 = byte |
| req_bit | input | 1 | Single-bit access |
| req_stack | input | 1 | Stack access (forces data segment) |
| req_use_es | input | 1 | Select extra segment instead of data segment |
| ds_i | input | 8 | Data segment byte |
| es_i | input | 8 | Extra segment byte |
| out_valid | output | 1 | Registered request valid |
| phys_addr | output | 24 | Physical byte address |
| word_addr | output | 23 | Physical word address |
| sel | output | 4 | One-hot target: 0 RAM, 1 on-chip SFR, 2 external SFR, 3 external memory |
| bitable | output | 1 | SFR address lies in the bit-addressable range |
| bit_err | output | 1 | Bit access to a non-bitable SFR |
| align_warn | output | 1 | Word request had an odd offset |

## Verification
The only state is the output register, so a wrong internal decision shows up at the ports in the very next cycle. It appears as a wrong target bit, a segment byte leaking into an SFR address, or a warning flag that is missing or stays high. The bench compares every output field on every clock against a behavioural model. A mis-decode therefore surfaces at the first request that crosses the faulty boundary: 0x3FF/0x400, 0x5FF/0x600, 0x43F/0x440, or the internal RAM limit.

// File: rtl/dar_pkg.sv
package dar_pkg;
  localparam int OFS_W = 16;
  localparam int SEG_W = 8;
  localparam int PA_W  = OFS_W + SEG_W;
  localparam int DIR_W = 11;

  typedef enum logic [1:0] {
    TGT_RAM    = 2'd0,
    TGT_SFR_ON = 2'd1,
    TGT_SFR_EX = 2'd2,
    TGT_EXTMEM = 2'd3
  } target_e;

  // Clear bit 0 of an offset for word accesses.
  function automatic logic [OFS_W-1:0] align_ofs(input logic [OFS_W-1:0] ofs,
                                                 input logic word);
    return word ? {ofs[OFS_W-1:1], 1'b0} : ofs;
  endfunction

  // Stack accesses pin the data segment; otherwise the request chooses.
  function automatic logic [SEG_W-1:0] pick_seg(input logic stack, input logic use_es,
                                                input logic [SEG_W-1:0] ds,
                                                input logic [SEG_W-1:0] es);
    return (!stack && use_es) ? es : ds;
  endfunction

  function automatic logic [3:0] tgt_onehot(input target_e t);
    return 4'b0001 << t;
  endfunction
endpackage

// File: rtl/dar_seg_select.sv
module dar_seg_select
  import dar_pkg::*;
#(
  parameter int SW = SEG_W
) (
  input  logic          stack_i,
  input  logic          use_es_i,
  input  logic [SW-1:0] ds_i,
  input  logic [SW-1:0] es_i,
  output logic [SW-1:0] seg_o
);
  always_comb seg_o = pick_seg(stack_i, use_es_i, ds_i, es_i);
endmodule

// File: rtl/dar_target_decode.sv
module dar_target_decode
  import dar_pkg::*;
#(
  parameter int OW            = OFS_W,
  parameter int DW            = DIR_W,
  parameter int INT_RAM_BYTES = 1024,
  parameter int BIT_BYTES     = 64
) (
  input  logic [OW-1:0] ofs_i,
  input  logic          direct_i,
  output target_e       tgt_o,
  output logic          in_sfr_o,
  output logic          bitable_o
);
  localparam int SFR_BASE = 1 << (DW - 1);
  localparam int SFR_EXT  = SFR_BASE + (SFR_BASE / 2);
  localparam int BIT_TOP  = SFR_BASE + BIT_BYTES;

  logic [DW-1:0] dir_addr;
  assign dir_addr = ofs_i[DW-1:0];

  always_comb begin
    in_sfr_o  = 1'b0;
    bitable_o = 1'b0;
    if (direct_i) begin
      if (int'(dir_addr) < SFR_BASE) begin
        tgt_o = TGT_RAM;
      end else begin
        in_sfr_o  = 1'b1;
        tgt_o     = (int'(dir_addr) < SFR_EXT) ? TGT_SFR_ON : TGT_SFR_EX;
        bitable_o = int'(dir_addr) < BIT_TOP;
      end
    end else begin
      tgt_o = (int'(ofs_i) < INT_RAM_BYTES) ? TGT_RAM : TGT_EXTMEM;
    end
  end
endmodule

// File: rtl/dmem_addr_router.sv
module dmem_addr_router
  import dar_pkg::*;
#(
  parameter int INT_RAM_BYTES = 1024,
  parameter int BIT_BYTES     = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [15:0]      req_offset,
  input  logic             req_direct,
  input  logic             req_word,
  input  logic             req_bit,
  input  logic             req_stack,
  input  logic             req_use_es,
  input  logic [7:0]       ds_i,
  input  logic [7:0]       es_i,
  output logic             out_valid,
  output logic [23:0]      phys_addr,
  output logic [22:0]      word_addr,
  output logic [3:0]       sel,
  output logic             bitable,
  output logic             bit_err,
  output logic             align_warn
);
  localparam int SFR_BASE = 1 << (DIR_W - 1);
  localparam int BIT_TOP  = SFR_BASE + BIT_BYTES;

  logic [SEG_W-1:0] seg_w;
  logic [OFS_W-1:0] aofs_w;
  logic [OFS_W-1:0] eofs_w;
  target_e          tgt_w;
  logic             in_sfr_w;
  logic             bitable_w;
  logic [PA_W-1:0]  pa_w;
  logic             misalign_w;

  assign aofs_w     = align_ofs(req_offset, req_word);
  // Direct operands see only the low DIR_W bits.
  assign eofs_w     = req_direct ? {{(OFS_W-DIR_W){1'b0}}, aofs_w[DIR_W-1:0]} : aofs_w;
  assign misalign_w = req_word & req_offset[0];

  dar_seg_select u_seg (
    .stack_i (req_stack),
    .use_es_i(req_use_es),
    .ds_i    (ds_i),
    .es_i    (es_i),
    .seg_o   (seg_w)
  );

  dar_target_decode #(
    .INT_RAM_BYTES(INT_RAM_BYTES),
    .BIT_BYTES    (BIT_BYTES)
  ) u_dec (
    .ofs_i    (eofs_w),
    .direct_i (req_direct),
    .tgt_o    (tgt_w),
    .in_sfr_o (in_sfr_w),
    .bitable_o(bitable_w)
  );

  // SFR window is segment-free.
  assign pa_w = in_sfr_w ? {{SEG_W{1'b0}}, eofs_w} : {seg_w, eofs_w};

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      out_valid  <= 1'b0;
      phys_addr  <= '0;
      sel        <= '0;
      bitable    <= 1'b0;
      bit_err    <= 1'b0;
      align_warn <= 1'b0;
    end else begin
      out_valid  <= 1'b1;
      phys_addr  <= pa_w;
      sel        <= tgt_onehot(tgt_w);
      bitable    <= bitable_w;
      bit_err    <= req_bit & in_sfr_w & ~bitable_w;
      align_warn <= misalign_w;
    end
  end

  assign word_addr = phys_addr[PA_W-1:1];

  // R9: one-hot target when valid, nothing when idle
  a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(sel));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (sel == 4'b0 && !align_warn && !bit_err));
  // R4: indirect requests never reach the SFR window
  a_r4_no_indirect_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_direct) |=> (sel[1] == 1'b0 && sel[2] == 1'b0));
  // R2: SFR addresses carry no segment bits
  a_r2_sfr_unsegmented: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[1] || sel[2]) |-> (phys_addr[PA_W-1:DIR_W] == '0));
  // R6: word accesses land on an even address
  a_r6_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word) |=> (phys_addr[0] == 1'b0));
  // R8: warning lasts exactly the cycle after the odd word request
  a_r8_warn_cause: assert property (@(posedge clk) disable iff (!rst_n)
    align_warn |-> ($past(req_valid) && $past(req_word) && $past(req_offset[0])));
  // R3: bitable only inside the low SFR slice
  a_r3_bitable_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitable |-> (sel[1] && int'(phys_addr) < BIT_TOP));
  a_r3_biterr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> (!bitable && (sel[1] || sel[2])));
endmodule

// File: tb/tb_dmem_addr_router.sv
`timescale 1ns/1ps
module tb_dmem_addr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_offset = '0;
  logic        req_direct = 1'b0, req_word = 1'b0, req_bit = 1'b0;
  logic        req_stack = 1'b0, req_use_es = 1'b0;
  logic [7:0]  ds_i = '0, es_i = '0;
  logic        out_valid, bitable, bit_err, align_warn;
  logic [23:0] phys_addr;
  logic [22:0] word_addr;
  logic [3:0]  sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // expected values (model state, updated at drive time)
  int e_valid = 0, e_pa = 0, e_sel = 0, e_bitable = 0, e_biterr = 0, e_warn = 0;
  string e_tag = "R10";

  always #2 clk = ~clk;

  dmem_addr_router dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_direct(req_direct), .req_word(req_word), .req_bit(req_bit),
    .req_stack(req_stack), .req_use_es(req_use_es), .ds_i(ds_i), .es_i(es_i),
    .out_valid(out_valid), .phys_addr(phys_addr), .word_addr(word_addr),
    .sel(sel), .bitable(bitable), .bit_err(bit_err), .align_warn(align_warn)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural model of one request
  task automatic model(input bit v, input int ofs, input bit dir, input bit wd,
                       input bit bt, input bit stk, input bit ues, input int ds, input int es);
    int seg, a, tgt;
    e_valid = 0; e_pa = 0; e_sel = 0; e_bitable = 0; e_biterr = 0; e_warn = 0;
    if (!v) return;
    e_valid = 1;
    seg = stk ? ds : (ues ? es : ds);        // R5
    a = wd ? (ofs & 'hFFFE) : ofs;            // R6
    if (dir) begin
      a = a % 2048;                           // R1 low 11 bits
      if (a < 1024) begin tgt = 0; e_pa = seg * 65536 + a; end
      else begin
        tgt = (a < 1536) ? 1 : 2;             // R2
        e_pa = a;
        e_bitable = (a < 1088) ? 1 : 0;       // R3
        e_biterr = (bt && !e_bitable) ? 1 : 0;
      end
    end else begin
      tgt = (a < 1024) ? 0 : 3;               // R4 / R7
      e_pa = seg * 65536 + a;
    end
    e_sel = 1 << tgt;
    e_warn = (wd && (ofs % 2 == 1)) ? 1 : 0;  // R8
  endtask

  task automatic drive(input bit v, input int ofs, input bit dir, input bit wd,
                       input bit bt, input bit stk, input bit ues, input int ds,
                       input int es, input string tag);
    @(negedge clk);
    req_valid = v; req_offset = 16'(ofs); req_direct = dir; req_word = wd;
    req_bit = bt; req_stack = stk; req_use_es = ues; ds_i = 8'(ds); es_i = 8'(es);
    model(v, ofs, dir, wd, bt, stk, ues, ds, es);
    e_tag = tag;
  endtask

  // Compare every cycle, after the edge has settled
  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      chk(e_tag, "out_valid R9", int'(out_valid), e_valid);
      chk(e_tag, "phys_addr", int'(phys_addr), e_pa);
      chk(e_tag, "word_addr R6", int'(word_addr), e_pa / 2);
      chk(e_tag, "sel", int'(sel), e_sel);
      chk(e_tag, "bitable R3", int'(bitable), e_bitable);
      chk(e_tag, "bit_err R3", int'(bit_err), e_biterr);
      chk(e_tag, "align_warn R8", int'(align_warn), e_warn);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state with active inputs
    req_valid = 1'b1; req_offset = 16'h0500; req_direct = 1'b1; req_word = 1'b1; req_offset[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset out", {31'b0, out_valid} | int'(sel) | int'(phys_addr) |
        int'(align_warn) | int'(bit_err) | int'(bitable), 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    rst_n = 1'b1;
    // R1 direct RAM with segment, upper offset bits ignored
    drive(1, 'h03FF, 1, 0, 0, 0, 0, 'h12, 'h34, "R1");
    drive(1, 'hF800, 1, 0, 0, 0, 1, 'h12, 'h34, "R1");
    // R2 SFR boundaries, segment ignored
    drive(1, 'h0400, 1, 0, 0, 0, 1, 'hAA, 'hBB, "R2");
    drive(1, 'h05FF, 1, 0, 0, 0, 0, 'hAA, 'hBB, "R2");
    drive(1, 'h0600, 1, 0, 0, 0, 0, 'hAA, 'hBB, "R2");
    drive(1, 'h07FF, 1, 0, 0, 0, 0, 'hAA, 'hBB, "R2");
    // R3 bit range edges
    drive(1, 'h043F, 1, 0, 1, 0, 0, 1, 2, "R3");
    drive(1, 'h0440, 1, 0, 1, 0, 0, 1, 2, "R3");
    drive(1, 'h0700, 1, 0, 1, 0, 0, 1, 2, "R3");
    drive(1, 'h0100, 1, 0, 1, 0, 0, 1, 2, "R3");
    // R4 indirect into SFR-looking offsets
    drive(1, 'h0450, 0, 0, 1, 0, 0, 0, 0, "R4");
    drive(1, 'h0650, 0, 0, 0, 0, 1, 0, 7, "R4");
    // R5 segment choice
    drive(1, 'h2000, 0, 0, 0, 1, 1, 'h11, 'h22, "R5");
    drive(1, 'h2000, 0, 0, 0, 0, 1, 'h11, 'h22, "R5");
    drive(1, 'h2000, 0, 0, 0, 0, 0, 'h11, 'h22, "R5");
    // R7 internal precedence boundary
    drive(1, 'h03FF, 0, 0, 0, 0, 0, 'h40, 0, "R7");
    drive(1, 'h0400, 0, 0, 0, 0, 0, 'h40, 0, "R7");
    drive(1, 'h0401, 0, 1, 0, 0, 0, 'h40, 0, "R7");
    // R6 / R8 odd words, then back-to-back even
    drive(1, 'h1235, 0, 1, 0, 0, 1, 5, 6, "R8");
    drive(1, 'h1234, 0, 1, 0, 0, 1, 5, 6, "R8");
    drive(1, 'h05FF, 1, 1, 0, 0, 0, 5, 6, "R6");
    drive(1, 'h0601, 1, 1, 0, 0, 0, 5, 6, "R6");
    // R9 idle with odd word pending on the pins
    drive(0, 'h0501, 1, 1, 1, 0, 0, 9, 9, "R9");
    drive(0, 'h0000, 0, 0, 0, 0, 0, 0, 0, "R9");
    // mixed patterns
    for (int i = 0; i < 2000; i++) begin
      drive(($urandom % 8) != 0, int'($urandom % 65536), $urandom % 2, $urandom % 2,
            $urandom % 2, $urandom % 2, $urandom % 2, int'($urandom % 256),
            int'($urandom % 256), "R9");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule